// File: doc/BRIEF.md
# Camera Pixel Byte Unpacker

This block sits behind an 8-bit parallel image-sensor port. It samples the port in the system clock domain and picks out the chosen transition of the sensor's pixel clock. It takes one byte on each such transition, but only while the line window is open, the frame is not in vertical blanking, and the block is enabled. It then gathers the bytes into complete pixel words.

The format select says how many bytes make a group and how each group maps onto the output word. The block supports YCbCr 4:2:2 pairs with four byte orders, RGB 5:6:5 with four byte patterns, RGB 8:8:8, and grayscale. Grayscale has a two-pixel packing and a one-pixel packing. The sensor's line sync, frame sync and clock edge each have their own polarity input. A finished word is presented with a single-cycle valid strobe.

Top module: `cam_byte_unpacker`

## Requirements
- R1: Bytes are taken one per selected pixel-clock transition. A transition is rising when `pclk_pol`=0 and falling when `pclk_pol`=1. Holding the pixel clock at one level takes no further bytes. `out_valid` rises for exactly one cycle, at the system clock edge that samples the final byte of a group.
- R2: With `fmt`=0 (YCbCr), a group is four bytes and `out_word` = {Y0,Y1,Cb,Cr}, with Y0 in bits 31:24 and Cr in bits 7:0. The byte order for each `ycc_order` value is:
  - 0: Cb,Y0,Cr,Y1
  - 1: Cr,Y0,Cb,Y1
  - 2: Y0,Cb,Y1,Cr
  - 3: Y0,Cr,Y1,Cb
- R3: With `fmt`=1 (RGB 5:6:5), a group is two bytes and `out_word` = {16'h0,R[4:0],G[5:0],B[4:0]}. For each `rgb_order` value, the first and second bytes (MSB first) are:
  - 0: {R,G[5:3]} then {G[2:0],B}
  - 1: {B,G[5:3]} then {G[2:0],R}
  - 2: {G[2:0],R} then {B,G[5:3]}
  - 3: {G[2:0],B} then {R,G[5:3]}
- R4: With `fmt`=2 (RGB 8:8:8), a group is three bytes and `out_word` = {8'h0,R,G,B}. The bytes arrive as R,G,B when `rgb_order[0]`=0 and as B,G,R when it is 1.
- R5: With `fmt`=3 (grayscale) and `gray_one`=0, a group is two luma bytes L0,L1 and `out_word` = {8'h0,L1,8'h0,L0}. With `gray_one`=1, a group is one byte and `out_word` = {24'h0,L0}.
- R6: When the line window closes, the byte position returns to the group start. A partial group is dropped and never completed by bytes of the next line.
- R7: Bytes that arrive while the frame sync is active are ignored and produce no output. They also leave no partial group behind.
- R8: Bytes that arrive while `enable` is low are ignored and produce no output.
- R9: The line window is open when `hsync` differs from `hsync_pol`. The frame sync is active when `vsync` differs from `vsync_pol`.
- R10: After reset, `out_valid` is 0 and `out_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Capture enable |
| px_clk | input | 1 | Sensor pixel clock, sampled by `clk` |
| hsync | input | 1 | Sensor line sync |
| vsync | input | 1 | Sensor frame sync |
| px_data | input | 8 | Sensor data byte |
| pclk_pol | input | 1 | 0: rising pixel-clock edge, 1: falling |
| hsync_pol | input | 1 | Line window open when `hsync` differs from this |
| vsync_pol | input | 1 | Frame sync active when `vsync` differs from this |
| fmt | input | 2 | 0 YCbCr, 1 RGB565, 2 RGB888, 3 grayscale |
| ycc_order | input | 2 | YCbCr byte order |
| rgb_order | input | 2 | RGB byte pattern |
| gray_one | input | 1 | Grayscale: 1 pixel per word when 1, else 2 |
| out_word | output | 32 | Assembled pixel word |
| out_valid | output | 1 | One-cycle strobe for `out_word` |

## Verification
The bench walks all four YCbCr orders and all four 5:6:5 patterns with bytes that differ in every position. A design that swapped the luma and chroma slots, or the high and low green bits, therefore yields a wrong word rather than an accidentally equal one.

It ends lines on a partial group and then sends a fresh group. A byte-position counter that survives the line gap would emit a word that mixes the two lines. It also sends full groups during frame blanking and with the block disabled; a design that ignores either gate would emit words nobody expects.

It holds the pixel clock active for several cycles, which catches level detection taking repeated bytes. It also inverts all three polarities at once, which catches a hard-wired edge or window sense.

// File: rtl/cam_byte_unpacker.sv
module cam_byte_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        px_clk,
  input  logic        hsync,
  input  logic        vsync,
  input  logic [7:0]  px_data,
  input  logic        pclk_pol,
  input  logic        hsync_pol,
  input  logic        vsync_pol,
  input  logic [1:0]  fmt,
  input  logic [1:0]  ycc_order,
  input  logic [1:0]  rgb_order,
  input  logic        gray_one,
  output logic [31:0] out_word,
  output logic        out_valid
);

  logic       pclk_q;
  logic [1:0] phase;
  logic [1:0] last_idx;
  logic [7:0] grp [3];
  logic [7:0] b0, b1, b2, b3;
  logic [31:0] asm_word;

  wire pclk_edge   = pclk_pol ? (pclk_q & ~px_clk) : (px_clk & ~pclk_q);
  wire line_act    = hsync ^ hsync_pol;
  wire frame_blank = vsync ^ vsync_pol;
  wire open_win    = enable & line_act & ~frame_blank;
  wire take        = open_win & pclk_edge;

  always_comb begin
    case (fmt)
      2'd0:    last_idx = 2'd3;
      2'd1:    last_idx = 2'd1;
      2'd2:    last_idx = 2'd2;
      default: last_idx = gray_one ? 2'd0 : 2'd1;
    endcase
  end

  assign b0 = (phase == 2'd0) ? px_data : grp[0];
  assign b1 = (phase == 2'd1) ? px_data : grp[1];
  assign b2 = (phase == 2'd2) ? px_data : grp[2];
  assign b3 = px_data;

  always_comb begin
    asm_word = 32'h0;
    case (fmt)
      2'd0: case (ycc_order)
        2'd0: asm_word = {b1, b3, b0, b2};
        2'd1: asm_word = {b1, b3, b2, b0};
        2'd2: asm_word = {b0, b2, b1, b3};
        default: asm_word = {b0, b2, b3, b1};
      endcase
      2'd1: case (rgb_order)
        2'd0: asm_word = {16'h0, b0, b1};
        2'd1: asm_word = {16'h0, b1[4:0], b0[2:0], b1[7:5], b0[7:3]};
        2'd2: asm_word = {16'h0, b0[4:0], b1[2:0], b0[7:5], b1[7:3]};
        default: asm_word = {16'h0, b1[7:3], b1[2:0], b0[7:5], b0[4:0]};
      endcase
      2'd2: asm_word = rgb_order[0] ? {8'h0, b2, b1, b0} : {8'h0, b0, b1, b2};
      default: asm_word = gray_one ? {24'h0, b0} : {8'h0, b1, 8'h0, b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pclk_q    <= 1'b0;
      phase     <= 2'd0;
      out_valid <= 1'b0;
      out_word  <= 32'h0;
      grp[0]    <= 8'h0;
      grp[1]    <= 8'h0;
      grp[2]    <= 8'h0;
    end else begin
      pclk_q    <= px_clk;
      out_valid <= 1'b0;
      if (!open_win) begin
        phase <= 2'd0;
      end else if (take) begin
        if (phase != 2'd3) grp[phase] <= px_data;
        if (phase == last_idx) begin
          phase     <= 2'd0;
          out_valid <= 1'b1;
          out_word  <= asm_word;
        end else begin
          phase <= phase + 2'd1;
        end
      end
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r6_line_gap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !line_act |=> (phase == 2'd0));

  a_r7_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_blank) |-> !out_valid);

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> !out_valid);

endmodule

// File: tb/test_cam_byte_unpacker.sv
module test_cam_byte_unpacker;
  logic clk = 0, rst_n = 0, enable = 0, px_clk = 0, hsync = 0, vsync = 0;
  logic [7:0] px_data = 0;
  logic pclk_pol = 0, hsync_pol = 0, vsync_pol = 0, gray_one = 0;
  logic [1:0] fmt = 0, ycc_order = 0, rgb_order = 0;
  logic [31:0] out_word;
  logic out_valid;
  int checks = 0, errors = 0, hold = 2;
  bit done = 0;
  string cur_req = "R1";
  logic [31:0] expq[$];

  always #4 clk = ~clk;

  cam_byte_unpacker i_cam_byte_unpacker (.*);

  function automatic logic [31:0] model(input logic [7:0] a, b, c, d);
    logic [4:0] r, bl; logic [5:0] g;
    case (fmt)
      2'd0: case (ycc_order)
        2'd0: return {b, d, a, c};
        2'd1: return {b, d, c, a};
        2'd2: return {a, c, b, d};
        default: return {a, c, d, b};
      endcase
      2'd1: begin
        case (rgb_order)
          2'd0: begin r = a[7:3]; g = {a[2:0], b[7:5]}; bl = b[4:0]; end
          2'd1: begin bl = a[7:3]; g = {a[2:0], b[7:5]}; r = b[4:0]; end
          2'd2: begin g = {b[2:0], a[7:5]}; r = a[4:0]; bl = b[7:3]; end
          default: begin g = {b[2:0], a[7:5]}; bl = a[4:0]; r = b[7:3]; end
        endcase
        return {16'h0, r, g, bl};
      end
      2'd2: return rgb_order[0] ? {8'h0, c, b, a} : {8'h0, a, b, c};
      default: return gray_one ? {24'h0, a} : {8'h0, b, 8'h0, a};
    endcase
  endfunction

  function automatic int gsize();
    case (fmt)
      2'd0: return 4;
      2'd1: return 2;
      2'd2: return 3;
      default: return gray_one ? 1 : 2;
    endcase
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk); px_data = b; px_clk = ~pclk_pol;
    repeat (hold) @(negedge clk);
    px_clk = pclk_pol;
    repeat (2) @(negedge clk);
  endtask

  task automatic line(input bit on);
    @(negedge clk); hsync = on ^ hsync_pol; repeat (2) @(negedge clk);
  endtask

  task automatic group(input logic [7:0] a, b, c, d, input bit expect_out);
    logic [7:0] v[4];
    v = '{a, b, c, d};
    if (expect_out) expq.push_back(model(a, b, c, d));
    for (int k = 0; k < gsize(); k++) send(v[k]);
  endtask

  task automatic drained(input string req);
    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s: pending outputs actual %0d expected 0", req, expq.size());
      expq.delete();
    end
  endtask

  always @(negedge clk) if (rst_n && out_valid) begin
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL %s: unexpected word actual %h expected none", cur_req, out_word);
    end else begin
      logic [31:0] e;
      e = expq.pop_front();
      if (out_word !== e) begin
        errors++;
        $display("FAIL %s: word actual %h expected %h", cur_req, out_word, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_word !== 32'h0) begin
      errors++;
      $display("FAIL R10: reset actual %b/%h expected 0/0", out_valid, out_word);
    end
    rst_n = 1; enable = 1;
    repeat (2) @(negedge clk);

    cur_req = "R2";
    line(1);
    for (int o = 0; o < 4; o++) begin
      ycc_order = 2'(o);
      group(8'h11 + 8'(o), 8'h52, 8'hA3, 8'hE4, 1);
    end
    line(0);
    drained("R2");

    cur_req = "R3"; fmt = 1;
    line(1);
    for (int o = 0; o < 4; o++) begin
      rgb_order = 2'(o);
      group(8'b1011_0110, 8'b0100_1101 ^ 8'(o), 0, 0, 1);
    end
    line(0);
    drained("R3");

    cur_req = "R4"; fmt = 2;
    line(1);
    rgb_order = 0; group(8'h12, 8'h34, 8'h56, 0, 1);
    rgb_order = 1; group(8'h9A, 8'hBC, 8'hDE, 0, 1);
    line(0);
    drained("R4");

    cur_req = "R5"; fmt = 3;
    line(1);
    gray_one = 0; group(8'h21, 8'h87, 0, 0, 1);
    gray_one = 1; group(8'h5C, 0, 0, 0, 1); group(8'hC5, 0, 0, 0, 1);
    line(0);
    drained("R5");

    cur_req = "R6"; fmt = 0; ycc_order = 0; gray_one = 0;
    line(1);
    send(8'hAA); send(8'hBB); send(8'hCC);
    line(0); line(1);
    group(8'h01, 8'h02, 8'h03, 8'h04, 1);
    line(0);
    drained("R6");

    cur_req = "R7";
    line(1);
    @(negedge clk); vsync = 1 ^ vsync_pol;
    send(8'h77); send(8'h66);
    group(8'h10, 8'h20, 8'h30, 8'h40, 0);
    @(negedge clk); vsync = vsync_pol;
    group(8'h31, 8'h32, 8'h33, 8'h34, 1);
    line(0);
    drained("R7");

    cur_req = "R8";
    line(1);
    @(negedge clk); enable = 0;
    send(8'h99);
    group(8'h41, 8'h42, 8'h43, 8'h44, 0);
    @(negedge clk); enable = 1;
    group(8'h45, 8'h46, 8'h47, 8'h48, 1);
    line(0);
    drained("R8");

    cur_req = "R1"; hold = 6;
    line(1);
    group(8'h61, 8'h62, 8'h63, 8'h64, 1);
    line(0);
    hold = 2;
    drained("R1");

    cur_req = "R9";
    @(negedge clk);
    pclk_pol = 1; px_clk = 1; hsync_pol = 1; vsync_pol = 1;
    hsync = 1; vsync = 1;
    repeat (2) @(negedge clk);
    line(1);
    ycc_order = 3;
    group(8'h81, 8'h82, 8'h83, 8'h84, 1);
    line(0);
    line(1);
    @(negedge clk); vsync = 0;
    group(8'h91, 8'h92, 8'h93, 8'h94, 0);
    @(negedge clk); vsync = 1;
    line(0);
    drained("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule